// File: doc/BRIEF.md
# Parallel I/O Port with Output-Compare Pin Takeover

This block is an 8-bit general-purpose parallel port. Software sees two registers: a port value register that holds output data, and a direction register that makes each pin an input or an output. Reading the value register never changes any state. Each bit returns one of two levels. An input bit returns the synchronized level seen on the pin. An output bit returns the level the block is applying to that pin's driver.

Each pin can also be taken over by a timer output-compare channel. The channel does this through a per-bit enable and a per-bit value. While a channel holds a pin, the pin driver is always on and carries the channel's value. CPU writes still reach the internal data latch, but they do not reach that pin. The held value becomes visible on the pin once the channel lets the pin go.

Pad electrical behaviour, the timer itself, interrupts and bus-mode pin reuse are handled elsewhere. The block only drives pin output-enable and pin output-value signals.

Top module: `gpio_ovr_port`

## Requirements
- R1: A synchronous active-high reset clears the data latch and the direction register to zero. Every pin output enable is then low unless its takeover enable is high.
- R2: A write at offset 0 always updates the data latch, whatever the direction bits are. A value written while a pin is an input appears on that pin once its direction bit is set.
- R3: With takeover off, a pin's output enable equals its direction bit. A 1 in the direction register selects output.
- R4: With takeover off, a pin's output value is the data latch bit, one clock after the write.
- R5: A read at offset 0 of an input bit returns that pin's level as sampled two clocks earlier, through a two-flop synchronizer.
- R6: A read at offset 0 of an output bit returns the level driven to the pin driver, not the pad level.
- R7: With a bit's takeover enable high, its output enable is 1, its output value equals the takeover value, and a read at offset 0 returns the takeover value.
- R8: A CPU write at offset 0 does not change the driven value of a pin that is taken over. The written value drives the pin after the takeover is released, while the direction bit is 1.
- R9: The direction register is written and read at offset 1.
- R10: A read at any offset other than 0 or 1 returns zero, and a write at such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | ADDR_W (2) | Register offset: 0 = data, 1 = direction |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | WIDTH (8) | Write data |
| regRdData | output | WIDTH (8) | Read data for the addressed register (combinational) |
| ovrEn | input | WIDTH (8) | Per-bit takeover enable from the output-compare unit |
| ovrVal | input | WIDTH (8) | Per-bit takeover value |
| pinIn | input | WIDTH (8) | Pin input levels |
| pinOe | output | WIDTH (8) | Per-pin driver enable |
| pinOut | output | WIDTH (8) | Per-pin driven value |

## Verification
Directed sequences cover three cases. The first writes data while all pins are inputs and then turns on the outputs, which separates latch update from pin drive. The second writes during a takeover and then releases it, which shows the pin held and the latch still updated. The third reads input pins whose levels differ from the latch, which exposes the two-clock synchronizer delay. Random cycles then mix direction masks, partial takeover masks, all offsets and changing pin levels. In these cycles the bits are in different states within one read word, so a read-back mux that chooses per word instead of per bit does not match the model.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  // register offsets decoded by the control module
  localparam int OFS_DATA = 0;
  localparam int OFS_DIR  = 1;

  // strobes passed from control to datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
  } portStrobe_t;
endpackage

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output portStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(OFS_DIR);

  logic hitData;
  logic hitDir;

  always_comb begin
    hitData = (regAddr == DATA_ADDR);
    hitDir  = (regAddr == DIR_ADDR);
  end

  always_comb begin
    strobe.wrData = regWrEn & hitData;
    strobe.wrDir  = regWrEn & hitDir;
    strobe.rdData = hitData;
    strobe.rdDir  = hitDir;
  end
endmodule

// File: rtl/gpio_ovr_datapath.sv
module gpio_ovr_datapath
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] ovrEn,
  input  logic [WIDTH-1:0] ovrVal,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] rdData
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dataLatch;
  logic [WIDTH-1:0] dirBits;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] pinSeen;
  logic [WIDTH-1:0] drvOe;
  logic [WIDTH-1:0] drvVal;
  logic [WIDTH-1:0] portView;

  // software-visible registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dataLatch <= '0;
      dirBits   <= '0;
    end else begin
      if (strobe.wrData) dataLatch <= wrData;
      if (strobe.wrDir)  dirBits   <= wrData;
    end
  end

  // input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncStage[0] <= '0;
          else     syncStage[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncStage[s] <= '0;
          else     syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  assign pinSeen = syncStage[LAST_STAGE];

  // per-bit driver selection and read-back view
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign drvOe[b]    = ovrEn[b] | dirBits[b];
      assign drvVal[b]   = ovrEn[b] ? ovrVal[b] : dataLatch[b];
      assign portView[b] = drvOe[b] ? drvVal[b] : pinSeen[b];
    end
  endgenerate

  assign pinOe  = drvOe;
  assign pinOut = drvVal;

  always_comb begin
    if (strobe.rdData)     rdData = portView;
    else if (strobe.rdDir) rdData = dirBits;
    else                   rdData = '0;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  ovrEn,
  input  logic [WIDTH-1:0]  ovrVal,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  pinOut
);
  portStrobe_t strobe;

  gpio_ovr_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_ovr_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (regWrData),
    .ovrEn  (ovrEn),
    .ovrVal (ovrVal),
    .pinIn  (pinIn),
    .pinOe  (pinOe),
    .pinOut (pinOut),
    .rdData (regRdData)
  );
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WIDTH-1:0]  regWrData,
  input logic [WIDTH-1:0]  regRdData,
  input logic [WIDTH-1:0]  ovrEn,
  input logic [WIDTH-1:0]  ovrVal,
  input logic [WIDTH-1:0]  pinIn,
  input logic [WIDTH-1:0]  pinOe,
  input logic [WIDTH-1:0]  pinOut
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);

  // cycles since reset release, saturating at 3
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_fresh_oe_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((pinOe & ~ovrEn) == '0));

  p_wr_reach_r2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == A_DATA) |=> ((pinOut & ~ovrEn) == ($past(regWrData) & ~ovrEn)));

  p_dir_oe_r3: assert property (@(posedge clk) disable iff (rst)
    (regAddr == A_DIR) |-> ((pinOe & ~ovrEn) == (regRdData & ~ovrEn)));

  p_in_lag_r5: assert property (@(posedge clk) disable iff (rst)
    (regAddr == A_DATA && sinceRst >= 2'd2) |-> (((regRdData ^ $past(pinIn, 2)) & ~pinOe) == '0));

  p_out_view_r6: assert property (@(posedge clk) disable iff (rst)
    (regAddr == A_DATA) |-> ((regRdData & pinOe) == (pinOut & pinOe)));

  p_takeover_r7: assert property (@(posedge clk) disable iff (rst)
    ((pinOe & ovrEn) == ovrEn) && ((pinOut & ovrEn) == (ovrVal & ovrEn)));

  p_spare_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (regAddr != A_DATA && regAddr != A_DIR) |-> (regRdData == '0));
endmodule

bind gpio_ovr_port gpio_ovr_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .ovrEn     (ovrEn),
  .ovrVal    (ovrVal),
  .pinIn     (pinIn),
  .pinOe     (pinOe),
  .pinOut    (pinOut)
);

// File: tb/gpio_ovr_port_tb.sv
`timescale 1ns/100ps
module gpio_ovr_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] ovrEn = '0;
  logic [7:0] ovrVal = '0;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOe;
  logic [7:0] pinOut;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ovr_port dut_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ovrEn(ovrEn),
    .ovrVal(ovrVal), .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut)
  );

  // behavioural reference state
  logic [7:0] mData = '0;
  logic [7:0] mDir  = '0;
  logic [7:0] pinHist [$];

  always @(posedge clk) begin
    if (rst) begin
      mData = '0;
      mDir  = '0;
      pinHist.delete();
    end else begin
      if (regWrEn && regAddr == 2'd0) mData = regWrData;
      if (regWrEn && regAddr == 2'd1) mDir  = regWrData;
      pinHist.push_front(pinIn);
      if (pinHist.size() > 2) void'(pinHist.pop_back());
    end
  end

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [7:0] eOe, eOut, eSeen, eRd;
    string tOe, tOut, tRd;
    eOe   = mDir | ovrEn;
    eOut  = (ovrEn & ovrVal) | (~ovrEn & mData);
    eSeen = (pinHist.size() >= 2) ? pinHist[1] : 8'h00;
    case (regAddr)
      2'd0:    eRd = (eOe & eOut) | (~eOe & eSeen);
      2'd1:    eRd = mDir;
      default: eRd = 8'h00;
    endcase
    tOe  = (ovrEn != 0) ? "R7" : "R3";
    tOut = (ovrEn != 0) ? "R7" : "R4";
    if (regAddr == 2'd0)      tRd = (ovrEn != 0) ? "R7" : ((mDir != 0) ? "R6" : "R5");
    else if (regAddr == 2'd1) tRd = "R9";
    else                      tRd = "R10";
    if (tag != "") begin tOe = tag; tOut = tag; tRd = tag; end
    check(tOe,  "pinOe",  pinOe,     eOe);
    check(tOut, "pinOut", pinOut,    eOut);
    check(tRd,  "rdData", regRdData, eRd);
  endtask

  task automatic cyc(input logic [1:0] a, input logic we, input logic [7:0] wd,
                     input logic [7:0] ov, input logic [7:0] ovv, input logic [7:0] pin,
                     input string tag);
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = wd;
    ovrEn = ov; ovrVal = ovv; pinIn = pin;
    #1;
    compareAll(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    cyc(2'd1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R1");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R1");
    // R2: write while all inputs, then enable outputs
    cyc(2'd0, 1'b1, 8'hA5, 8'h00, 8'h00, 8'h5A, "R2");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h5A, "R2");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h5A, "R2");
    cyc(2'd1, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h5A, "R9");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R2");
    // R8: write during takeover, then release
    cyc(2'd0, 1'b0, 8'h00, 8'hFF, 8'h0F, 8'h00, "R7");
    cyc(2'd0, 1'b1, 8'h3C, 8'hFF, 8'h0F, 8'h00, "R8");
    cyc(2'd0, 1'b0, 8'h00, 8'hFF, 8'h0F, 8'h00, "R8");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h0F, 8'h00, "R8");
    // R10: spare offsets read zero and ignore writes
    cyc(2'd2, 1'b1, 8'h77, 8'h00, 8'h00, 8'h00, "R10");
    cyc(2'd3, 1'b1, 8'h11, 8'h00, 8'h00, 8'h00, "R10");
    cyc(2'd1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R10");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R10");
    // R5: input read lags the pin by two clocks
    cyc(2'd1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, "R9");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hC3, "R5");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R5");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R5");
    cyc(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "R5");
    // mixed random cycles
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ov;
      ov = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      cyc(2'($urandom), ($urandom_range(0, 2) == 0), 8'($urandom),
          ov, 8'($urandom), 8'($urandom), "");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule